// File: doc/BRIEF.md
# System Clock Configuration Controller

The block chooses which qualified clock-enable stream drives the system clock and how far that stream is divided. Every clock is modelled as a one-cycle enable pulse on a common fast clock. The candidate streams are a main oscillator, an internal fast oscillator, that fast oscillator divided by four (made inside the block), a slow internal oscillator, a real-time oscillator and a PLL output. From the chosen system tick the block also derives a PWM tick, by a power-of-two ratio, and an ADC tick, taken straight from the PLL stream.

Software programs three registers through a simple write/read port. The run register holds the full configuration. The override register can replace the source, divisor, bypass and power-down fields of the run register. The sleep register supplies the source and divisor while the deep-sleep input is high. A change of source or divisor waits for the end of the current system-tick period, so no short period is ever produced.

Top module: `sysclk_cfg_ctrl`

## Requirements
- R1: After reset, the run register (address 0) reads 0x19 and the override register (address 1) reads 0x19. The sleep register (address 2) reads 0x01 and address 3 reads 0. So the source is the internal fast oscillator, bypass is set, the PLL is powered down and no ADC tick appears.
- R2: Source field bits [2:0] select the stream: 0 main, 1 internal fast, 2 internal fast divided by four, 3 slow, 4 real-time. The codes 5, 6 and 7 select the internal fast oscillator. A read returns the stored code unchanged.
- R3: Source code 2 gives one system tick for every four internal-fast ticks.
- R4: When bit 9 of the run register is set, the divisor field bits [8:5] holding N gives one system tick every N+1 source ticks. When bit 9 is clear, each source tick gives one system tick.
- R5: When bypass (bit 3) and power-down (bit 4) are both clear, the system tick comes from the PLL stream and the source field is ignored. Otherwise the stream named by the source field is used.
- R6: When bit 15 of the override register is set, the override register's source, bypass, power-down and divisor fields (same bit positions as the run register) replace those of the run register. Clearing bit 15 restores the run register fields.
- R7: While the deep-sleep input is high, the source comes from bits [2:0] of the sleep register and the divisor from its bits [8:5]. The divisor is still enabled by run bit 9, and the PLL path is not used.
- R8: With bit 10 of the run register set, the PWM tick occurs once every 2^(k+1) system ticks, where k is field [13:11] limited to 5. With bit 10 clear, the PWM tick follows every system tick.
- R9: While the PLL is powered up, the ADC tick occurs once every 25 PLL ticks when bit 14 is clear and once every 50 when it is set. While the PLL is powered down, no ADC tick occurs.
- R10: A new source or divisor takes effect only after the system tick that ends the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast common clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 run, 1 override, 2 sleep) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| sleep_i | input | 1 | Deep-sleep request |
| iosc_tick_i | input | 1 | Internal fast oscillator tick |
| mosc_tick_i | input | 1 | Main oscillator tick |
| slow_tick_i | input | 1 | Slow internal oscillator tick |
| rtc_tick_i | input | 1 | Real-time oscillator tick |
| pll_tick_i | input | 1 | PLL output tick |
| sys_tick_o | output | 1 | System clock enable |
| pwm_tick_o | output | 1 | PWM clock enable |
| adc_tick_o | output | 1 | ADC clock enable |

## Verification
The bench changes the divisor partway through a period and checks that the old period still completes before the new ratio starts. A design that switched at once would cut a period short, or would run its counter past the new limit and stall. It checks that reserved source codes fall back to the fast oscillator and still read back as written; a design that decoded them literally would stop producing ticks. It checks that override and deep-sleep each take priority over the run register, and that the ADC tick stops when the PLL is powered down. It also checks the top PWM codes, which a design that did not limit the shift would turn into wrong or zero ratios.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int SYSDIV_W = 4;
  localparam int NSRC     = 6;

  localparam int B_BYP     = 3;
  localparam int B_PWD     = 4;
  localparam int B_DIV_LO  = 5;
  localparam int B_USE_DIV = 9;
  localparam int B_USE_PWM = 10;
  localparam int B_PWM_LO  = 11;
  localparam int B_ADC_ALT = 14;
  localparam int B_OVR     = 15;

  localparam logic [31:0] RUN_MASK = 32'h0000_7fff;
  localparam logic [31:0] OVR_MASK = 32'h0000_81ff;
  localparam logic [31:0] SLP_MASK = 32'h0000_01e7;
  localparam logic [31:0] RUN_RST  = 32'h0000_0019;
  localparam logic [31:0] OVR_RST  = 32'h0000_0019;
  localparam logic [31:0] SLP_RST  = 32'h0000_0001;

  typedef enum logic [2:0] {
    SEL_MOSC  = 3'd0,
    SEL_IOSC  = 3'd1,
    SEL_IOSC4 = 3'd2,
    SEL_SLOW  = 3'd3,
    SEL_RTC   = 3'd4,
    SEL_PLL   = 3'd5
  } sel_e;

  typedef struct packed {
    sel_e                sel;
    logic [SYSDIV_W-1:0] div;
    logic                pll_on;
    logic                use_pwm;
    logic [2:0]          pwm_enc;
    logic                adc_alt;
  } cfg_t;

  function automatic sel_e map_src(input logic [2:0] f);
    case (f)
      3'd0:    map_src = SEL_MOSC;
      3'd2:    map_src = SEL_IOSC4;
      3'd3:    map_src = SEL_SLOW;
      3'd4:    map_src = SEL_RTC;
      default: map_src = SEL_IOSC;
    endcase
  endfunction
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  // >= so that a shrinking ratio never strands the counter
  assign last = (ratio_i <= W'(1)) || (cnt_q >= ratio_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (tick_i) begin
      cnt_q  <= last ? '0 : cnt_q + W'(1);
      tick_o <= last;
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_cfg_regs.sv
module clk_cfg_regs
  import clk_cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        sleep_i,
  output logic [31:0] rdata_o,
  output cfg_t        cfg_o
);
  logic [31:0] run_q, ovr_q, slp_q;
  logic [2:0]          eff_src;
  logic                eff_byp, eff_pwd;
  logic [SYSDIV_W-1:0] eff_div;
  logic                use_div;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= RUN_RST;
      ovr_q <= OVR_RST;
      slp_q <= SLP_RST;
    end else if (wr_en_i) begin
      case (addr_i)
        2'd0:    run_q <= wdata_i & RUN_MASK;
        2'd1:    ovr_q <= wdata_i & OVR_MASK;
        2'd2:    slp_q <= wdata_i & SLP_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      2'd0:    rdata_o = run_q;
      2'd1:    rdata_o = ovr_q;
      2'd2:    rdata_o = slp_q;
      default: rdata_o = '0;
    endcase
  end

  always_comb begin
    if (ovr_q[B_OVR]) begin
      eff_src = ovr_q[2:0];
      eff_byp = ovr_q[B_BYP];
      eff_pwd = ovr_q[B_PWD];
      eff_div = ovr_q[B_DIV_LO +: SYSDIV_W];
    end else begin
      eff_src = run_q[2:0];
      eff_byp = run_q[B_BYP];
      eff_pwd = run_q[B_PWD];
      eff_div = run_q[B_DIV_LO +: SYSDIV_W];
    end
    use_div = run_q[B_USE_DIV];

    cfg_o.pll_on  = !eff_pwd;
    cfg_o.use_pwm = run_q[B_USE_PWM];
    cfg_o.pwm_enc = run_q[B_PWM_LO +: 3];
    cfg_o.adc_alt = run_q[B_ADC_ALT];
    if (sleep_i) begin
      cfg_o.sel = map_src(slp_q[2:0]);
      cfg_o.div = use_div ? slp_q[B_DIV_LO +: SYSDIV_W] : '0;
    end else begin
      cfg_o.sel = (!eff_byp && !eff_pwd) ? SEL_PLL : map_src(eff_src);
      cfg_o.div = use_div ? eff_div : '0;
    end
  end
endmodule

// File: rtl/clk_sys_div.sv
module clk_sys_div
  import clk_cfg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NSRC-1:0]     src_tick_i,
  input  sel_e                req_sel_i,
  input  logic [SYSDIV_W-1:0] req_div_i,
  output logic                tick_o
);
  sel_e                act_sel_q;
  logic [SYSDIV_W-1:0] act_div_q, cnt_q;
  logic                sel_tick, wrap;

  assign sel_tick = src_tick_i[act_sel_q];
  assign wrap     = (cnt_q == act_div_q);

  // new selection is loaded only on the tick that closes a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sel_q <= SEL_IOSC;
      act_div_q <= '0;
      cnt_q     <= '0;
      tick_o    <= 1'b0;
    end else if (sel_tick) begin
      tick_o <= wrap;
      if (wrap) begin
        cnt_q     <= '0;
        act_sel_q <= req_sel_i;
        act_div_q <= req_div_i;
      end else begin
        cnt_q <= cnt_q + SYSDIV_W'(1);
      end
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sysclk_cfg_ctrl.sv
module sysclk_cfg_ctrl
  import clk_cfg_pkg::*;
#(
  parameter int IOSC_PRE    = 4,
  parameter int ADC_DIV_PRI = 25,
  parameter int ADC_DIV_ALT = 50
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        sleep_i,
  input  logic        iosc_tick_i,
  input  logic        mosc_tick_i,
  input  logic        slow_tick_i,
  input  logic        rtc_tick_i,
  input  logic        pll_tick_i,
  output logic        sys_tick_o,
  output logic        pwm_tick_o,
  output logic        adc_tick_o
);
  localparam int PRE_W = $clog2(IOSC_PRE + 1);
  localparam int ADC_MAX = (ADC_DIV_PRI > ADC_DIV_ALT) ? ADC_DIV_PRI : ADC_DIV_ALT;
  localparam int ADC_W = $clog2(ADC_MAX + 1);
  localparam int PWM_W = 7;

  cfg_t            cfg;
  logic            iosc4_tick;
  logic [NSRC-1:0] src_tick;
  logic            pll_on;
  logic [2:0]      pwm_sh;
  logic [PWM_W-1:0] pwm_ratio;
  logic [ADC_W-1:0] adc_ratio;

  tick_div #(.W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(1'b0), .tick_i(iosc_tick_i),
    .ratio_i(PRE_W'(IOSC_PRE)), .tick_o(iosc4_tick)
  );

  clk_cfg_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .sleep_i(sleep_i), .rdata_o(rdata_o), .cfg_o(cfg)
  );

  assign src_tick = {pll_tick_i, rtc_tick_i, slow_tick_i, iosc4_tick, iosc_tick_i, mosc_tick_i};
  assign pll_on   = cfg.pll_on;

  clk_sys_div u_sys (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_tick_i(src_tick),
    .req_sel_i(cfg.sel), .req_div_i(cfg.div), .tick_o(sys_tick_o)
  );

  assign pwm_sh    = (cfg.pwm_enc > 3'd5) ? 3'd5 : cfg.pwm_enc;
  assign pwm_ratio = cfg.use_pwm ? (PWM_W'(2) << pwm_sh) : PWM_W'(1);

  tick_div #(.W(PWM_W)) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(1'b0), .tick_i(sys_tick_o),
    .ratio_i(pwm_ratio), .tick_o(pwm_tick_o)
  );

  assign adc_ratio = cfg.adc_alt ? ADC_W'(ADC_DIV_ALT) : ADC_W'(ADC_DIV_PRI);

  tick_div #(.W(ADC_W)) u_adc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!pll_on), .tick_i(pll_tick_i),
    .ratio_i(adc_ratio), .tick_o(adc_tick_o)
  );
endmodule

// File: rtl/sysclk_cfg_chk.sv
module sysclk_cfg_chk
  import clk_cfg_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] src_tick,
  input logic            pll_tick_i,
  input logic            pll_on,
  input logic            sys_tick_o,
  input logic            pwm_tick_o,
  input logic            adc_tick_o
);
  assert_sys_has_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_tick_o |-> $past(|src_tick));

  assert_pwm_follows_sys_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_tick_o |-> $past(sys_tick_o));

  assert_adc_follows_pll_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_tick_o |-> $past(pll_tick_i));

  assert_adc_needs_pll_on_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_tick_o |-> $past(pll_on));
endmodule

bind sysclk_cfg_ctrl sysclk_cfg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_tick(src_tick), .pll_tick_i(pll_tick_i),
  .pll_on(pll_on), .sys_tick_o(sys_tick_o), .pwm_tick_o(pwm_tick_o),
  .adc_tick_o(adc_tick_o)
);

// File: tb/sysclk_cfg_ctrl_tb.sv
`timescale 1ns/1ps
module sysclk_cfg_ctrl_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sleep = 1'b0;
  logic [4:0] tk = '0; // 0 main, 1 fast, 2 slow, 3 rtc, 4 pll
  logic sys_tick, pwm_tick, adc_tick;

  always #4 clk = ~clk;

  sysclk_cfg_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sleep_i(sleep), .iosc_tick_i(tk[1]), .mosc_tick_i(tk[0]),
    .slow_tick_i(tk[2]), .rtc_tick_i(tk[3]), .pll_tick_i(tk[4]),
    .sys_tick_o(sys_tick), .pwm_tick_o(pwm_tick), .adc_tick_o(adc_tick)
  );

  localparam logic [4:0] M_MOSC = 5'h01, M_IOSC = 5'h02, M_SLOW = 5'h04,
                         M_RTC = 5'h08, M_PLL = 5'h10, M_ALL = 5'h1f;

  int n_sys = 0, n_pwm = 0, n_adc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {string tag; int kind; int exp;} exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    if (sys_tick) n_sys++;
    if (pwm_tick) n_pwm++;
    if (adc_tick) n_adc++;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected counts and compares with observed ones
  initial begin
    forever begin
      exp_t e;
      int act;
      wait (q.size() > 0);
      e = q.pop_front();
      case (e.kind)
        0: act = n_sys;
        1: act = n_pwm;
        default: act = n_adc;
      endcase
      chk(e.tag, act, e.exp);
    end
  end

  task automatic expect_cnt(int kind, int exp, string tag);
    exp_t e;
    e.tag = tag; e.kind = kind; e.exp = exp;
    q.push_back(e);
    wait (q.size() == 0);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, int exp, string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic pulse(logic [4:0] m);
    @(negedge clk);
    tk = m;
    @(negedge clk);
    tk = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_cnt();
    n_sys = 0; n_pwm = 0; n_adc = 0;
  endtask

  task automatic warm();
    repeat (80) pulse(M_ALL);
    repeat (6) @(negedge clk);
  endtask

  task automatic run(logic [4:0] m, int n);
    clr_cnt();
    repeat (n) pulse(m);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd_chk(2'd0, 32'h19, "R1 run reg reset");
    rd_chk(2'd1, 32'h19, "R1 ovr reg reset");
    rd_chk(2'd2, 32'h01, "R1 slp reg reset");
    rd_chk(2'd3, 0, "R1 unmapped addr");
    run(M_IOSC, 8);  expect_cnt(0, 8, "R1 fast osc drives sys after reset");
    run(M_MOSC, 8);  expect_cnt(0, 0, "R1 main osc unused after reset");
    run(M_PLL, 50);  expect_cnt(2, 0, "R1 pll down no adc tick");

    // R3 fast/4
    wr(2'd0, 32'h1a); warm();
    run(M_IOSC, 16); expect_cnt(0, 4, "R3 fast div4 source");

    // R4 system divisor
    wr(2'd0, 32'h258); warm();
    run(M_MOSC, 12); expect_cnt(0, 4, "R4 divide by 3");
    wr(2'd0, 32'h058); warm();
    run(M_MOSC, 12); expect_cnt(0, 12, "R4 use bit clear undivided");

    // R5 PLL path
    wr(2'd0, 32'h000); warm();
    run(M_PLL, 10);  expect_cnt(0, 10, "R5 pll drives sys");
    run(M_MOSC, 10); expect_cnt(0, 0, "R5 source field ignored with pll");
    wr(2'd0, 32'h240); warm();
    run(M_PLL, 9);   expect_cnt(0, 3, "R5 pll with divide by 3");
    wr(2'd0, 32'h008); warm();
    run(M_MOSC, 6);  expect_cnt(0, 6, "R5 bypass uses raw osc");

    // R6 override
    wr(2'd0, 32'h18); wr(2'd1, 32'h801b); warm();
    run(M_SLOW, 8);  expect_cnt(0, 8, "R6 override selects slow");
    run(M_MOSC, 8);  expect_cnt(0, 0, "R6 run source ignored");
    rd_chk(2'd1, 32'h801b, "R6 ovr readback");
    wr(2'd1, 32'h001b); warm();
    run(M_MOSC, 8);  expect_cnt(0, 8, "R6 override released");

    // R7 deep sleep
    wr(2'd0, 32'h218); wr(2'd2, 32'h24);
    @(negedge clk); sleep = 1'b1; warm();
    run(M_RTC, 8);   expect_cnt(0, 4, "R7 sleep rtc div 2");
    run(M_MOSC, 8);  expect_cnt(0, 0, "R7 run source ignored in sleep");
    @(negedge clk); sleep = 1'b0; warm();
    run(M_MOSC, 8);  expect_cnt(0, 8, "R7 run config after sleep");

    // R8 PWM
    wr(2'd0, 32'hc19); warm();
    run(M_IOSC, 16); expect_cnt(1, 4, "R8 pwm div 4");
    wr(2'd0, 32'h3c19); warm();
    run(M_IOSC, 128); expect_cnt(1, 2, "R8 pwm code 7 is div 64");
    wr(2'd0, 32'h0419); warm();
    run(M_IOSC, 10); expect_cnt(1, 5, "R8 pwm div 2");
    wr(2'd0, 32'h3819); warm();
    run(M_IOSC, 10); expect_cnt(1, 10, "R8 pwm equals sys");

    // R9 ADC
    wr(2'd0, 32'h0000); warm();
    run(M_PLL, 100); expect_cnt(2, 4, "R9 adc div 25");
    wr(2'd0, 32'h4000); warm();
    run(M_PLL, 100); expect_cnt(2, 2, "R9 adc div 50");
    wr(2'd0, 32'h4018); warm();
    run(M_PLL, 100); expect_cnt(2, 0, "R9 adc off when pll down");

    // R2 reserved source code
    wr(2'd0, 32'h1e);
    rd_chk(2'd0, 32'h1e, "R2 reserved code reads back");
    warm();
    run(M_IOSC, 8);  expect_cnt(0, 8, "R2 reserved falls back to fast");
    run(M_MOSC, 8);  expect_cnt(0, 0, "R2 reserved not main");

    // R10 change waits for period end
    wr(2'd0, 32'h278); warm();
    clr_cnt();
    for (int i = 0; i < 10; i++) begin
      pulse(M_MOSC);
      if (n_sys > 0) break;
    end
    clr_cnt();
    pulse(M_MOSC); pulse(M_MOSC);
    wr(2'd0, 32'h238);
    pulse(M_MOSC);
    expect_cnt(0, 0, "R10 no runt at tick 3");
    pulse(M_MOSC);
    expect_cnt(0, 1, "R10 old period ends at tick 4");
    pulse(M_MOSC);
    expect_cnt(0, 1, "R10 new ratio tick 5");
    pulse(M_MOSC);
    expect_cnt(0, 2, "R10 new ratio tick 6");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule